// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Sequencer

This block sits between a synchronous host and an external asynchronous static RAM of 256K words by 16 bits. The RAM has active-low chip select, write strobe, output enable and one select per byte. The host issues one request at a time: an 18-bit word address, a write flag, 16 bits of write data and a 2-bit lane mask. The sequencer turns each request into a strobe sequence on the memory pins whose lengths are counted in clock cycles. Every count is a parameter, rounded up from the memory's nanosecond limits at the chosen clock period.

A write keeps output enable high for its whole length, so the shorter write-pulse limit applies. The block drives the data bus only during the write pulse and the cycle after it, and never while the memory's outputs are enabled. When a write follows a read, a turnaround gap lets the memory's outputs float before the block drives the bus. A read captures the selected lanes on its last wait cycle and reports completion with a one-cycle pulse. Lanes that were not selected read back as zero.

Top module: `sram_lane_ctrl`

## Requirements
- R1: During and after reset, with no request, `host_ready` is 1, `host_done` is 0, `mem_dq_oe` is 0, and `mem_ce_n`, `mem_we_n`, `mem_oe_n`, `mem_lb_n` and `mem_ub_n` are all 1.
- R2: A read request asserts `mem_ce_n`=0 and `mem_oe_n`=0 with `mem_we_n`=1 for exactly RD_CYC cycles. It starts in the cycle after acceptance. Lane mask bit 0 selects the low byte (`mem_lb_n`=0) and bit 1 selects the high byte (`mem_ub_n`=0).
- R3: After a read, `host_rdata` holds the memory byte in each lane whose mask bit is 1 and zero in each lane whose mask bit is 0. The value stays unchanged until the next read completes, including across writes.
- R4: A write holds `mem_we_n`=0 for exactly max(PULSE_CYC, SETUP_CYC) cycles. Throughout that time `mem_ce_n`=0 and `mem_oe_n`=1.
- R5: A write changes only the memory lanes whose mask bit is 1. The other lane keeps its previous content.
- R6: `mem_dq_oe` is 1 from the first write-pulse cycle through exactly one cycle after `mem_we_n` rises, and 0 at all other times. Address and write data stay stable over that whole window.
- R7: `mem_dq_oe` and an active `mem_oe_n` (0) never occur in the same cycle.
- R8: A write accepted after a read, with no write in between, first holds `mem_ce_n`=1 and `mem_dq_oe`=0 for exactly TURN_CYC cycles. A write that follows a write starts its pulse in the cycle right after acceptance.
- R9: `host_done` is a single-cycle pulse in the cycle after an operation's last cycle. `host_ready` is 1 only when the block is idle. A request raised while the block is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_req | input | 1 | Request strobe, taken only while idle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 18 | Word address |
| host_wdata | input | 16 | Write data |
| host_mask | input | 2 | Lane select, bit 0 low byte, bit 1 high byte |
| host_ready | output | 1 | Idle, a request is accepted this cycle |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Data from the last read |
| mem_addr | output | 18 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Low byte select, active low |
| mem_ub_n | output | 1 | High byte select, active low |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the block's data driver |
| mem_dq_in | input | 16 | Data read from the memory bus |

## Verification
The assertions watch the bus-safety rules on every cycle. They check that the block never drives the bus while the memory's outputs are enabled, that output enable stays high and chip enable low under an active write strobe, that address and data hold steady through the write window, and that the completion pulse lasts one cycle. The bench scenarios show the rest: the exact strobe lengths, byte-lane masking on writes and reads, the held read value, the turnaround gap after a read, and that a request made while busy is dropped.

// File: rtl/sram_lane_pkg.sv
// Shared types for the byte-lane SRAM sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package sram_lane_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_TURN   = 3'd1,
        ST_WPULSE = 3'd2,
        ST_WREC   = 3'd3,
        ST_READ   = 3'd4
    } seq_state_t;
endpackage

// File: rtl/sram_wait_timer.sv
// Down-counter that measures the length of a sequencer phase.
// Assumes: loading N-1 makes the phase last N cycles; the count stops at zero.
module sram_wait_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // Load on a phase start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (load)       cnt_q <= load_val;
        else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // Once expired, the timer stays expired until it is loaded again.
    assert_timer_stays_expired_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load) |=> expired);
endmodule

// File: rtl/sram_seq_fsm.sv
// Phase sequencer: idle, turnaround, write pulse, write recovery, read.
// Assumes: every cycle count is at least 1; requests are taken only in idle.
module sram_seq_fsm
    import sram_lane_pkg::*;
#(
    parameter int RD_CYC    = 2,
    parameter int PULSE_CYC = 1,
    parameter int SETUP_CYC = 1,
    parameter int TURN_CYC  = 1,
    parameter int CNT_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_req,
    input  logic             host_we,
    input  logic             expired,
    output seq_state_t       state,
    output logic             accept,
    output logic             capture,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             done
);
    localparam int WP_CYC = (PULSE_CYC > SETUP_CYC) ? PULSE_CYC : SETUP_CYC;
    localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LD = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] TN_LD = CNT_W'(TURN_CYC - 1);

    seq_state_t state_q, state_d;
    logic       turn_pend_q, turn_pend_d;
    logic       done_q, done_d;

    // Next phase, timer load and completion decode.
    always_comb begin
        state_d     = state_q;
        turn_pend_d = turn_pend_q;
        accept      = 1'b0;
        capture     = 1'b0;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        done_d      = 1'b0;
        unique case (state_q)
            ST_IDLE: if (host_req) begin
                accept   = 1'b1;
                tmr_load = 1'b1;
                if (!host_we) begin
                    state_d = ST_READ;
                    tmr_val = RD_LD;
                end else if (turn_pend_q) begin
                    state_d = ST_TURN;
                    tmr_val = TN_LD;
                end else begin
                    state_d = ST_WPULSE;
                    tmr_val = WP_LD;
                end
            end
            ST_TURN: if (expired) begin
                state_d     = ST_WPULSE;
                tmr_load    = 1'b1;
                tmr_val     = WP_LD;
                turn_pend_d = 1'b0;
            end
            ST_WPULSE: if (expired) state_d = ST_WREC;
            ST_WREC: begin
                state_d = ST_IDLE;
                done_d  = 1'b1;
            end
            ST_READ: if (expired) begin
                state_d     = ST_IDLE;
                capture     = 1'b1;
                done_d      = 1'b1;
                turn_pend_d = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Phase, turnaround flag and done pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            turn_pend_q <= 1'b0;
            done_q      <= 1'b0;
        end else begin
            state_q     <= state_d;
            turn_pend_q <= turn_pend_d;
            done_q      <= done_d;
        end
    end

    assign state = state_q;
    assign done  = done_q;

    // A completion pulse never lasts more than one cycle.
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    // A completion pulse always lands in idle.
    assert_done_in_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (state_q == ST_IDLE));
endmodule

// File: rtl/sram_bus_io.sv
// Request latch, memory pin decode and read-data capture.
// Assumes: pins decode from the registered phase; lanes are 8 bits wide.
module sram_bus_io
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16,
    parameter int LANES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_t        state,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [LANES-1:0]  host_mask,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [LANES-1:0]  mem_be_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  mask_q;
    logic [DATA_W-1:0] rdata_q;
    logic              active;

    // Hold the accepted request for the whole operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
        end else if (accept) begin
            addr_q  <= host_addr;
            wdata_q <= host_wdata;
            mask_q  <= host_mask;
        end
    end

    // Pin decode from the current phase.
    always_comb begin
        active     = (state == ST_WPULSE) || (state == ST_WREC) || (state == ST_READ);
        mem_ce_n   = !active;
        mem_we_n   = (state != ST_WPULSE);
        mem_oe_n   = (state != ST_READ);
        mem_dq_oe  = (state == ST_WPULSE) || (state == ST_WREC);
        mem_be_n   = active ? ~mask_q : '1;
    end

    // Per-lane read capture on the last read cycle; unselected lanes load zero.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)       rdata_q[g*8 +: 8] <= '0;
            else if (capture) rdata_q[g*8 +: 8] <= mask_q[g] ? mem_dq_in[g*8 +: 8] : 8'h00;
        end
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign host_rdata = rdata_q;

    // Address and data stay put from an active write strobe into the next cycle.
    assert_write_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |=> ($stable(mem_addr) && $stable(mem_dq_out)));
    // Read data changes only at a capture.
    assert_rdata_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(capture) |-> $stable(host_rdata));
endmodule

// File: rtl/sram_lane_ctrl.sv
// Top: host request port to asynchronous 16-bit byte-lane SRAM pins.
// Assumes: one request in flight; counts at least 1 and rounded up from the
// memory's limits at the clock period; the data driver is external.
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 16,
    parameter int RD_CYC    = 2,
    parameter int PULSE_CYC = 1,
    parameter int SETUP_CYC = 1,
    parameter int TURN_CYC  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [1:0]        host_mask,
    output logic              host_ready,
    output logic              host_done,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int MAX_A  = (RD_CYC > PULSE_CYC) ? RD_CYC : PULSE_CYC;
    localparam int MAX_B  = (SETUP_CYC > TURN_CYC) ? SETUP_CYC : TURN_CYC;
    localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W  = (MAX_C < 2) ? 1 : $clog2(MAX_C);

    seq_state_t       state;
    logic             accept, capture, tmr_load, expired;
    logic [CNT_W-1:0] tmr_val;
    logic [1:0]       be_n;

    sram_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(expired)
    );

    sram_seq_fsm #(
        .RD_CYC(RD_CYC), .PULSE_CYC(PULSE_CYC), .SETUP_CYC(SETUP_CYC),
        .TURN_CYC(TURN_CYC), .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .expired(expired), .state(state), .accept(accept), .capture(capture),
        .tmr_load(tmr_load), .tmr_val(tmr_val), .done(host_done)
    );

    sram_bus_io #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(2)) u_io (
        .clk(clk), .rst_n(rst_n), .state(state), .accept(accept), .capture(capture),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_mask(host_mask),
        .host_rdata(host_rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_be_n(be_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    assign host_ready = (state == ST_IDLE);
    assign mem_lb_n   = be_n[0];
    assign mem_ub_n   = be_n[1];

    // The block never drives the bus while the memory may be driving it.
    assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe && !mem_oe_n));
    // An active write strobe always has chip enable low and output enable high.
    assert_write_oe_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && !mem_ce_n));
    // The driver turns on only at the start of a write pulse.
    assert_drive_starts_at_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> !mem_we_n);
    // Ready drops in the cycle after a request is taken.
    assert_busy_after_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ready && host_req) |=> !host_ready);
endmodule

// File: tb/test_sram_lane_ctrl.sv
module test_sram_lane_ctrl;
    localparam int RD = 3, PUL = 2, SET = 3, TRN = 2;
    localparam int WP = (PUL > SET) ? PUL : SET;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [17:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [1:0]  host_mask = '0;
    logic        host_ready, host_done;
    logic [15:0] host_rdata;
    logic [17:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
    logic [15:0] mem_dq_out;
    wire  [15:0] mem_dq_in;

    int checks = 0, errors = 0;
    logic [15:0] model [0:255];

    always #5 clk = ~clk;

    sram_lane_ctrl #(.RD_CYC(RD), .PULSE_CYC(PUL), .SETUP_CYC(SET), .TURN_CYC(TRN))
    i_sram_lane_ctrl (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_mask(host_mask),
        .host_ready(host_ready), .host_done(host_done), .host_rdata(host_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // Memory model: latch selected lanes when the write strobe rises.
    always @(posedge mem_we_n) begin
        if (rst_n && !mem_ce_n && mem_dq_oe) begin
            if (!mem_lb_n) model[mem_addr[7:0]][7:0]  <= mem_dq_out[7:0];
            if (!mem_ub_n) model[mem_addr[7:0]][15:8] <= mem_dq_out[15:8];
        end
    end
    assign mem_dq_in[7:0]  = (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_lb_n) ?
                             model[mem_addr[7:0]][7:0]  : 8'hzz;
    assign mem_dq_in[15:8] = (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_ub_n) ?
                             model[mem_addr[7:0]][15:8] : 8'hzz;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Measurements from the last operation.
    int n_pre, n_we, n_oe, n_dq, n_clash, n_bad_hold, n_done, n_lb, n_ub;

    // Run one operation; optionally raise a second request while busy.
    task automatic run_op(input logic we, input logic [17:0] a, input logic [15:0] d,
                          input logic [1:0] m, input bit poke);
        bit pulse_seen = 0;
        n_pre = 0; n_we = 0; n_oe = 0; n_dq = 0; n_clash = 0; n_bad_hold = 0;
        n_done = 0; n_lb = 0; n_ub = 0;
        @(negedge clk);
        host_req = 1; host_we = we; host_addr = a; host_wdata = d; host_mask = m;
        @(negedge clk);
        host_req = 0; host_wdata = ~d; host_addr = a ^ 18'h55;
        for (int k = 0; k < 60; k++) begin
            if (poke && k == 1) begin
                host_req = 1; host_we = 1; host_addr = 18'h0F0; host_mask = 2'b11;
            end else host_req = 0;
            if (host_done) break;
            if (host_ready) n_bad_hold++;
            if (!mem_we_n) begin
                n_we++; pulse_seen = 1;
                if (mem_addr !== a || mem_dq_out !== d) n_bad_hold++;
            end
            if (mem_ce_n && !pulse_seen) n_pre++;
            if (!mem_oe_n) n_oe++;
            if (mem_dq_oe) n_dq++;
            if (mem_dq_oe && !mem_oe_n) n_clash++;
            if (!mem_ce_n && !mem_lb_n) n_lb++;
            if (!mem_ce_n && !mem_ub_n) n_ub++;
            @(negedge clk);
        end
        host_req = 0;
        n_done = host_done ? 1 : 0;
        @(negedge clk);
        if (host_done) n_done++;
        for (int k = 0; k < 4; k++) begin
            if (host_done) n_done++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        rst_n = 0;
        repeat (3) @(negedge clk);
        check("R1 ready in reset", host_ready, 1);
        rst_n = 1;
        @(negedge clk);
        check("R1 idle strobes", {mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 5'h1F);
        check("R1 driver off", mem_dq_oe, 0);
        check("R1 no done", host_done, 0);
        check("R1 ready", host_ready, 1);
    endtask

    task automatic t_word(input logic [17:0] a, input logic [15:0] d);
        run_op(1, a, d, 2'b11, 0);
        check("R4 write pulse cycles", n_we, WP);
        check("R6 driver window", n_dq, WP + 1);
        check("R6 addr/data hold, busy", n_bad_hold, 0);
        check("R9 done single", n_done, 1);
        check("R7 clash", n_clash, 0);
        run_op(0, a, 16'h0, 2'b11, 0);
        check("R2 read oe cycles", n_oe, RD);
        check("R2 both lanes selected", {n_lb[7:0], n_ub[7:0]}, {8'(RD), 8'(RD)});
        check("R2 no driver in read", n_dq, 0);
        check("R3 word read", host_rdata, d);
    endtask

    task automatic t_lanes;
        run_op(1, 18'h21, 16'hAAAA, 2'b11, 0);
        run_op(1, 18'h21, 16'h1234, 2'b01, 0);
        run_op(0, 18'h21, 16'h0, 2'b11, 0);
        check("R5 low lane write", host_rdata, 16'hAA34);
        run_op(1, 18'h21, 16'h5678, 2'b10, 0);
        run_op(0, 18'h21, 16'h0, 2'b11, 0);
        check("R5 high lane write", host_rdata, 16'h5634);
        run_op(0, 18'h21, 16'h0, 2'b01, 0);
        check("R3 low lane read", host_rdata, 16'h0034);
        check("R2 only low select", {n_lb[7:0], n_ub[7:0]}, {8'(RD), 8'd0});
        run_op(0, 18'h21, 16'h0, 2'b10, 0);
        check("R3 high lane read", host_rdata, 16'h5600);
        run_op(1, 18'h22, 16'hBEEF, 2'b11, 0);
        check("R3 rdata held over write", host_rdata, 16'h5600);
    endtask

    task automatic t_turn;
        run_op(0, 18'h21, 16'h0, 2'b11, 0);
        run_op(1, 18'h30, 16'hC0DE, 2'b11, 0);
        check("R8 gap after read", n_pre, TRN);
        check("R7 clash after read", n_clash, 0);
        run_op(1, 18'h31, 16'hF00D, 2'b11, 0);
        check("R8 no gap after write", n_pre, 0);
    endtask

    task automatic t_busy;
        model[8'hF0] = 16'h1111;
        run_op(1, 18'h40, 16'h4242, 2'b11, 1);
        check("R9 one done for busy poke", n_done, 1);
        check("R9 ready after op", host_ready, 1);
        check("R9 poked address untouched", model[8'hF0], 16'h1111);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) model[i] = '0;
        t_reset();
        t_word(18'h10, 16'hA5C3);
        t_word(18'h11, 16'h0FF0);
        t_lanes();
        t_turn();
        t_busy();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule